// File: doc/BRIEF.md
# Dual-Encoder Overspeed and Movement Monitor

This block watches a lift car through two independent incremental quadrature encoders, one per channel. Each channel keeps a signed position count from a 4x quadrature decoder. At the end of every sample window (10 ms at the default clock) each channel's speed is taken as the count change over that window. The speeds, positions and four latched trip flags go to the downstream safety decision logic, which drops the brake when any flag is high.

Four conditions trip the block. Overspeed fires when either channel's speed magnitude is above 115 % of the rated speed. Unintended movement fires when the car is meant to be held still and either channel has drifted beyond a distance limit from the position captured when holding began. Channel discrepancy fires when the two speeds disagree by more than a tolerance for three windows in a row. Encoder fault fires on an impossible quadrature step. All flags stay set until a clear request arrives while none of the conditions is still present.

Two small state machines do the work. The hold machine has the states MOVING and HELD. It goes MOVING→HELD when `hold_req` is high, capturing both positions as the reference, and HELD→MOVING when `hold_req` falls. The trip machine has the states ARMED and TRIPPED. It goes ARMED→TRIPPED when any trip condition is seen. It goes TRIPPED→ARMED on an accepted clear, which also empties every flag. A 1-bit sample strobe from a free-running window counter paces the speed logic.

Top module: `enc_motion_monitor`

## Requirements
- R1: Each channel decodes its phases as the index {A, A xor B}, where (A,B) stepping 00→01→11→10→00 is forward. A one-step forward change adds 1 to the channel position and a one-step backward change subtracts 1. Position is 0 after reset.
- R2: A change of both phases between two samples of one channel leaves that position unchanged and sets `trip_encoder`.
- R3: Each channel's speed is its signed position change over the last completed window of SAMPLE_DIV clocks. It changes only at a window boundary and is 0 after a window with no steps.
- R4: `trip_overspeed` sets when |speed|·100 > `rated_speed`·115 on either channel, for either direction. Equality does not trip. The flag is raised within five windows of the condition starting.
- R5: The car position reference is taken when the hold machine enters HELD. While HELD, `trip_movement` sets when |position − reference| > `move_limit` on either channel. A displacement equal to the limit does not trip, and no movement is judged while `hold_req` is low.
- R6: `trip_discrep` sets when |speed0 − speed1| > `speed_tol` in three consecutive windows. A difference equal to the tolerance resets the run.
- R7: Every trip flag latches, and `trip_any` is high exactly when at least one flag is set.
- R8: `trip_clear` empties all flags only when there is no current overspeed sample, no movement beyond the limit while HELD, no discrepancy run and no encoder fault. Otherwise it is ignored.
- R9: After reset all trip flags, positions and speeds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 2 | Phase A, bit i for channel i |
| enc_b | input | 2 | Phase B, bit i for channel i |
| rated_speed | input | SPD_W | Rated speed in counts per window |
| speed_tol | input | SPD_W | Allowed speed difference between channels |
| move_limit | input | CNT_W | Movement limit in counts while held |
| hold_req | input | 1 | Car should be stationary |
| trip_clear | input | 1 | Request to clear latched trips |
| pos0 | output | CNT_W | Channel 0 signed position |
| pos1 | output | CNT_W | Channel 1 signed position |
| speed0 | output | SPD_W | Channel 0 signed speed |
| speed1 | output | SPD_W | Channel 1 signed speed |
| trip_overspeed | output | 1 | Latched overspeed trip |
| trip_movement | output | 1 | Latched unintended-movement trip |
| trip_discrep | output | 1 | Latched channel discrepancy trip |
| trip_encoder | output | 1 | Latched encoder fault trip |
| trip_any | output | 1 | Any trip latched |

## Verification
Overspeed and channel discrepancy are both judged on the same sample strobe, so they can set in the same cycle. The bench provokes this with channel 0 running at twice the step rate of channel 1, above the rated threshold. It then expects both flags high together and the speeds at their exact per-window counts. A clear request that arrives while the car is still displaced under hold is also applied. The bench expects it to be refused, and expects the same request to succeed once `hold_req` has dropped.

// File: rtl/enc_mon_pkg.sv
package enc_mon_pkg;

    typedef enum logic {HS_MOVING, HS_HELD} hold_st_e;

    typedef enum logic {TS_ARMED, TS_TRIPPED} trip_st_e;

    typedef struct packed {
        logic ovs;
        logic mov;
        logic dis;
        logic enc;
    } trip_flags_t;

    // quadrature phase pair mapped to a 0..3 ring index
    function automatic logic [1:0] quad_index(input logic a, input logic b);
        return {a, a ^ b};
    endfunction

endpackage

// File: rtl/quad_decoder.sv
module quad_decoder
    import enc_mon_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ph_a,
    input  logic                    ph_b,
    output logic signed [CNT_W-1:0] pos,
    output logic                    fault
);
    logic       a_m, a_s, b_m, b_s;
    logic       primed;
    logic [1:0] idx_q, idx_now, step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_m <= 1'b0; a_s <= 1'b0;
            b_m <= 1'b0; b_s <= 1'b0;
        end else begin
            a_m <= ph_a; a_s <= a_m;
            b_m <= ph_b; b_s <= b_m;
        end
    end

    always_comb begin
        idx_now = quad_index(a_s, b_s);
        step    = idx_now - idx_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= 2'd0;
            primed <= 1'b0;
            pos    <= '0;
            fault  <= 1'b0;
        end else begin
            idx_q  <= idx_now;
            primed <= 1'b1;
            fault  <= 1'b0;
            if (primed) begin
                unique case (step)
                    2'd1:    pos <= pos + 1'b1;
                    2'd3:    pos <= pos - 1'b1;
                    2'd2:    fault <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // R1: position never moves more than one count per clock
    p_single_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == $past(pos)) || (pos == $past(pos) + 1'b1) || (pos == $past(pos) - 1'b1));

    // R2: an illegal step does not move the count
    p_fault_no_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $stable(pos));

endmodule

// File: rtl/window_timer.sv
module window_timer #(
    parameter int SAMPLE_DIV = 1_250_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = $clog2(SAMPLE_DIV);
    localparam logic [TW-1:0] LAST = TW'(SAMPLE_DIV - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

endmodule

// File: rtl/speed_calc.sv
module speed_calc #(
    parameter int CNT_W = 24,
    parameter int SPD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic signed [CNT_W-1:0] pos,
    output logic signed [SPD_W-1:0] speed
);
    logic signed [CNT_W-1:0] pos_last, delta;

    assign delta = pos - pos_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_last <= '0;
            speed    <= '0;
        end else if (tick) begin
            pos_last <= pos;
            speed    <= delta[SPD_W-1:0];
        end
    end

    // R3: speed moves only at a window boundary
    p_speed_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(speed));

endmodule

// File: rtl/trip_supervisor.sv
module trip_supervisor
    import enc_mon_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int SPD_W    = 16,
    parameter int DISC_RUN = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic signed [CNT_W-1:0] pos [2],
    input  logic signed [SPD_W-1:0] spd [2],
    input  logic [1:0]              enc_fault,
    input  logic [SPD_W-1:0]        rated_speed,
    input  logic [SPD_W-1:0]        speed_tol,
    input  logic [CNT_W-1:0]        move_limit,
    input  logic                    hold_req,
    input  logic                    trip_clear,
    output logic                    trip_overspeed,
    output logic                    trip_movement,
    output logic                    trip_discrep,
    output logic                    trip_encoder,
    output logic                    trip_any
);
    localparam int MUL_W = SPD_W + 8;
    localparam int DW    = SPD_W + 2;
    localparam int RW    = $clog2(DISC_RUN + 1);

    hold_st_e    hs, hs_nx;
    trip_st_e    ts, ts_nx;
    trip_flags_t flags, sets;

    logic                    samp_q;
    logic                    os_now;
    logic [RW-1:0]           disc_cnt;
    logic signed [CNT_W-1:0] ref_q [2];

    logic [SPD_W:0]   sext [2];
    logic [SPD_W:0]   smag [2];
    logic [CNT_W-1:0] pd   [2];
    logic [CNT_W:0]   pext [2];
    logic [CNT_W:0]   pmag [2];
    logic [1:0]       os_hit, far;
    logic [MUL_W-1:0] os_lim;
    logic [DW-1:0]    sdiff, dmag;
    logic             over, mv_raw, clr_ok, any_set;

    // magnitudes and compares
    always_comb begin
        os_lim = MUL_W'(rated_speed) * MUL_W'(115);
        for (int i = 0; i < 2; i++) begin
            sext[i]   = {spd[i][SPD_W-1], spd[i]};
            smag[i]   = sext[i][SPD_W] ? (~sext[i] + 1'b1) : sext[i];
            os_hit[i] = (MUL_W'(smag[i]) * MUL_W'(100)) > os_lim;
            pd[i]     = pos[i] - ref_q[i];
            pext[i]   = {pd[i][CNT_W-1], pd[i]};
            pmag[i]   = pext[i][CNT_W] ? (~pext[i] + 1'b1) : pext[i];
            far[i]    = pmag[i] > {1'b0, move_limit};
        end
        sdiff  = {{2{spd[0][SPD_W-1]}}, spd[0]} - {{2{spd[1][SPD_W-1]}}, spd[1]};
        dmag   = sdiff[DW-1] ? (~sdiff + 1'b1) : sdiff;
        over   = dmag > DW'(speed_tol);
        mv_raw = (hs == HS_HELD) && (|far);
    end

    always_comb begin
        sets.ovs = samp_q && (|os_hit);
        sets.mov = mv_raw;
        sets.dis = samp_q && over && (disc_cnt >= RW'(DISC_RUN - 1));
        sets.enc = |enc_fault;
        any_set  = |sets;
        clr_ok   = trip_clear && !os_now && !mv_raw && (disc_cnt == '0) && !(|enc_fault);
    end

    // hold machine: next state
    always_comb begin
        unique case (hs)
            HS_MOVING: hs_nx = hold_req ? HS_HELD : HS_MOVING;
            HS_HELD:   hs_nx = hold_req ? HS_HELD : HS_MOVING;
        endcase
    end

    // trip machine: next state
    always_comb begin
        unique case (ts)
            TS_ARMED:   ts_nx = any_set ? TS_TRIPPED : TS_ARMED;
            TS_TRIPPED: ts_nx = (clr_ok && !any_set) ? TS_ARMED : TS_TRIPPED;
        endcase
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs <= HS_MOVING;
            ts <= TS_ARMED;
        end else begin
            hs <= hs_nx;
            ts <= ts_nx;
        end
    end

    // reference capture and sample bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q[0] <= '0;
            ref_q[1] <= '0;
            samp_q   <= 1'b0;
            os_now   <= 1'b0;
            disc_cnt <= '0;
        end else begin
            samp_q <= tick;
            if (hs == HS_MOVING && hold_req) begin
                ref_q[0] <= pos[0];
                ref_q[1] <= pos[1];
            end
            if (samp_q) begin
                os_now <= |os_hit;
                if (!over)                          disc_cnt <= '0;
                else if (disc_cnt != RW'(DISC_RUN)) disc_cnt <= disc_cnt + 1'b1;
            end
        end
    end

    // outputs: latched flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                flags <= '0;
        else if (ts == TS_TRIPPED && ts_nx == TS_ARMED) flags <= '0;
        else                                       flags <= flags | sets;
    end

    assign trip_overspeed = flags.ovs;
    assign trip_movement  = flags.mov;
    assign trip_discrep   = flags.dis;
    assign trip_encoder   = flags.enc;
    assign trip_any       = (ts == TS_TRIPPED);

    // R7: machine state and flag set agree
    p_any_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trip_any == (|flags));

    // R7: overspeed stays latched without a clear request
    p_latch_ovs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_overspeed && !trip_clear) |=> trip_overspeed);

    // R8: trips only drop after a clear request
    p_clear_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trip_any) |-> $past(trip_clear));

    // R5: reference frozen while held
    p_ref_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs == HS_HELD && $past(hs) == HS_HELD) |-> ($stable(ref_q[0]) && $stable(ref_q[1])));

    // R5: movement trip only raised from the held state
    p_move_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_movement) |-> $past(hs) == HS_HELD);

    // R6: discrepancy needs a full run of mismatched windows
    p_disc_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_discrep) |-> $past(disc_cnt) >= RW'(DISC_RUN - 1));

endmodule

// File: rtl/enc_motion_monitor.sv
module enc_motion_monitor
    import enc_mon_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int SPD_W      = 16,
    parameter int SAMPLE_DIV = 1_250_000,
    parameter int DISC_RUN   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              enc_a,
    input  logic [1:0]              enc_b,
    input  logic [SPD_W-1:0]        rated_speed,
    input  logic [SPD_W-1:0]        speed_tol,
    input  logic [CNT_W-1:0]        move_limit,
    input  logic                    hold_req,
    input  logic                    trip_clear,
    output logic signed [CNT_W-1:0] pos0,
    output logic signed [CNT_W-1:0] pos1,
    output logic signed [SPD_W-1:0] speed0,
    output logic signed [SPD_W-1:0] speed1,
    output logic                    trip_overspeed,
    output logic                    trip_movement,
    output logic                    trip_discrep,
    output logic                    trip_encoder,
    output logic                    trip_any
);
    logic                    tick;
    logic signed [CNT_W-1:0] pos_w [2];
    logic signed [SPD_W-1:0] spd_w [2];
    logic [1:0]              flt_w;

    window_timer #(.SAMPLE_DIV(SAMPLE_DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        quad_decoder #(.CNT_W(CNT_W)) u_dec (
            .clk  (clk),
            .rst_n(rst_n),
            .ph_a (enc_a[ch]),
            .ph_b (enc_b[ch]),
            .pos  (pos_w[ch]),
            .fault(flt_w[ch])
        );
        speed_calc #(.CNT_W(CNT_W), .SPD_W(SPD_W)) u_spd (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .pos  (pos_w[ch]),
            .speed(spd_w[ch])
        );
    end

    trip_supervisor #(.CNT_W(CNT_W), .SPD_W(SPD_W), .DISC_RUN(DISC_RUN)) u_sup (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .pos           (pos_w),
        .spd           (spd_w),
        .enc_fault     (flt_w),
        .rated_speed   (rated_speed),
        .speed_tol     (speed_tol),
        .move_limit    (move_limit),
        .hold_req      (hold_req),
        .trip_clear    (trip_clear),
        .trip_overspeed(trip_overspeed),
        .trip_movement (trip_movement),
        .trip_discrep  (trip_discrep),
        .trip_encoder  (trip_encoder),
        .trip_any      (trip_any)
    );

    assign pos0   = pos_w[0];
    assign pos1   = pos_w[1];
    assign speed0 = spd_w[0];
    assign speed1 = spd_w[1];

endmodule

// File: tb/enc_motion_monitor_tb.sv
module enc_motion_monitor_tb;
    localparam int WIN = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] enc_a = 2'b00, enc_b = 2'b00;
    logic [15:0] rated_speed = 16'd1000, speed_tol = 16'd1000;
    logic [23:0] move_limit = 24'd30;
    logic hold_req = 1'b0, trip_clear = 1'b0;
    logic signed [23:0] pos0, pos1;
    logic signed [15:0] speed0, speed1;
    logic trip_overspeed, trip_movement, trip_discrep, trip_encoder, trip_any;

    always #4 clk = ~clk;

    enc_motion_monitor #(.CNT_W(24), .SPD_W(16), .SAMPLE_DIV(WIN), .DISC_RUN(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .rated_speed(rated_speed), .speed_tol(speed_tol), .move_limit(move_limit),
        .hold_req(hold_req), .trip_clear(trip_clear),
        .pos0(pos0), .pos1(pos1), .speed0(speed0), .speed1(speed1),
        .trip_overspeed(trip_overspeed), .trip_movement(trip_movement),
        .trip_discrep(trip_discrep), .trip_encoder(trip_encoder), .trip_any(trip_any)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;
    int idx [2] = '{0, 0};
    int epos [2] = '{0, 0};

    typedef struct packed {
        int p0; int p1; int rev; int rated; int tol;
        int s0; int s1; int ovs; int dis;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{10, 10, 0,  20, 2, 20, 20, 0, 0},
        '{10, 10, 0,  17, 2, 20, 20, 1, 0},
        '{10, 10, 1,  17, 2, -20, -20, 1, 0},
        '{ 5,  5, 0,  35, 2, 40, 40, 0, 0},
        '{ 5,  5, 0,  34, 2, 40, 40, 1, 0},
        '{10, 20, 0, 100, 3, 20, 10, 0, 1},
        '{10,  8, 0, 100, 5, 20, 25, 0, 0},
        '{ 5, 10, 0,  30, 3, 40, 20, 1, 1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put_phase(input int ch);
        logic [1:0] q;
        q = 2'(idx[ch]);
        enc_a[ch] = q[1];
        enc_b[ch] = q[1] ^ q[0];
    endtask

    task automatic step(input int ch, input int rev);
        idx[ch] = rev ? idx[ch] - 1 : idx[ch] + 1;
        epos[ch] = rev ? epos[ch] - 1 : epos[ch] + 1;
        put_phase(ch);
    endtask

    task automatic drive(input int ch, input int per, input int rev, input int len);
        if (per == 0) repeat (len) @(negedge clk);
        else for (int k = 0; k < len / per; k++) begin
            repeat (per) @(negedge clk);
            step(ch, rev);
        end
    endtask

    task automatic clear_pulse();
        @(negedge clk) trip_clear = 1'b1;
        @(negedge clk) trip_clear = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(trip_any == 0 && trip_overspeed == 0 && trip_movement == 0, "R9 trips after reset", int'(trip_any), 0);
        chk(pos0 == 0 && pos1 == 0, "R9 positions after reset", int'(pos0), 0);
        chk(speed0 == 0 && speed1 == 0, "R9 speeds after reset", int'(speed0), 0);

        // table of speed/trip vectors (R3 R4 R6 R1)
        for (int v = 0; v < 8; v++) begin
            rated_speed = 16'(VEC[v].rated);
            speed_tol   = 16'(VEC[v].tol);
            fork
                drive(0, VEC[v].p0, VEC[v].rev, 6 * WIN);
                drive(1, VEC[v].p1, VEC[v].rev, 6 * WIN);
                begin
                    repeat (5 * WIN) @(negedge clk);
                    chk(int'(speed0) == VEC[v].s0, $sformatf("R3 speed0 vec%0d", v), int'(speed0), VEC[v].s0);
                    chk(int'(speed1) == VEC[v].s1, $sformatf("R3 speed1 vec%0d", v), int'(speed1), VEC[v].s1);
                    chk(int'(trip_overspeed) == VEC[v].ovs, $sformatf("R4 overspeed vec%0d", v), int'(trip_overspeed), VEC[v].ovs);
                    chk(int'(trip_discrep) == VEC[v].dis, $sformatf("R6 discrepancy vec%0d", v), int'(trip_discrep), VEC[v].dis);
                    chk(int'(trip_any) == (VEC[v].ovs | VEC[v].dis), $sformatf("R7 any vec%0d", v), int'(trip_any), VEC[v].ovs | VEC[v].dis);
                end
            join
            repeat (3 * WIN) @(negedge clk);
            chk(int'(pos0) == epos[0] && int'(pos1) == epos[1], $sformatf("R1 position vec%0d", v), int'(pos0), epos[0]);
            chk(speed0 == 0, $sformatf("R3 idle speed vec%0d", v), int'(speed0), 0);
            if (VEC[v].ovs != 0)
                chk(trip_overspeed == 1, $sformatf("R7 overspeed held vec%0d", v), int'(trip_overspeed), 1);
            clear_pulse();
            chk(trip_any == 0, $sformatf("R8 clear accepted vec%0d", v), int'(trip_any), 0);
        end

        // movement under hold (R5 R8)
        rated_speed = 16'd1000; speed_tol = 16'd1000; move_limit = 24'd30;
        hold_req = 1'b1;
        repeat (5) @(negedge clk);
        drive(0, 4, 0, 120);
        repeat (10) @(negedge clk);
        chk(trip_movement == 0, "R5 displacement equal to limit", int'(trip_movement), 0);
        drive(0, 4, 0, 4);
        repeat (10) @(negedge clk);
        chk(trip_movement == 1, "R5 displacement over limit", int'(trip_movement), 1);
        clear_pulse();
        chk(trip_movement == 1, "R8 clear refused while displaced", int'(trip_movement), 1);
        hold_req = 1'b0;
        repeat (5) @(negedge clk);
        clear_pulse();
        chk(trip_any == 0, "R8 clear accepted after hold release", int'(trip_any), 0);

        // no movement judged without hold (R5)
        drive(0, 4, 0, 200);
        repeat (10) @(negedge clk);
        chk(trip_movement == 0, "R5 motion ignored without hold", int'(trip_movement), 0);
        // fresh reference on re-entering hold (R5)
        hold_req = 1'b1;
        repeat (5) @(negedge clk);
        drive(0, 4, 1, 80);
        repeat (10) @(negedge clk);
        chk(trip_movement == 0, "R5 reference recaptured", int'(trip_movement), 0);
        hold_req = 1'b0;
        repeat (5) @(negedge clk);
        chk(int'(pos0) == epos[0], "R1 position after hold tests", int'(pos0), epos[0]);

        // encoder fault (R2 R7 R8)
        @(negedge clk);
        idx[1] = idx[1] + 2;
        put_phase(1);
        repeat (8) @(negedge clk);
        chk(trip_encoder == 1, "R2 double transition trips", int'(trip_encoder), 1);
        chk(trip_any == 1, "R7 any on encoder fault", int'(trip_any), 1);
        chk(int'(pos1) == epos[1], "R2 position held on fault", int'(pos1), epos[1]);
        clear_pulse();
        chk(trip_encoder == 0 && trip_any == 0, "R8 encoder trip cleared", int'(trip_any), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule